// File: doc/BRIEF.md
# Transmit Descriptor Slot Ring

This block keeps the bookkeeping for a small ring of transmit descriptor slots in front of a packet DMA engine. It holds two free-running counters: one advanced by every accepted packet submission from the host, and one advanced by every completion reported by the engine. The slot a new packet goes into is the low bits of the submission counter. The gap between the two counters is the number of packets in flight, and the ring reports full when every slot holds one.

For the packet being offered, the block also forms the status/length word that the host writes into the chosen slot. The engine does not pad short frames, so the length field is raised to the 60-byte minimum frame size. A transmit FIFO threshold, given in bytes, goes into a six-bit field higher in the same word. The block also checks the buffer start address and raises a flag when the buffer is not 4-byte aligned. The host then has to copy the packet into an aligned bounce buffer first. A recovery strobe restarts the ring after an engine reset. Packets still in flight are taken to be reloaded from slot 0 upward, so the completion counter returns to 0 and the submission counter takes the number of packets that were pending.

Top module: `tx_slot_ring`

## Requirements
- R1: `slot_o` equals the submission count modulo 4. Each accepted submission advances it by one, and it wraps from 3 to 0.
- R2: `copy_o` is 1 exactly when bit 1 or bit 0 of `sub_addr_i` is set.
- R3: Bits 12..0 of `word_o` hold `sub_len_i` when it is 60 or more, and 60 when it is shorter.
- R4: Bits 21..16 of `word_o` hold bits 10..5 of `thresh_i`. Every other bit above bit 12 is zero.
- R5: `full_o` is 1 exactly when the submission count minus the completion count equals 4.
- R6: A submit strobe seen while `full_o` is 1 has no effect.
- R7: A completion strobe seen while the two counts are equal has no effect.
- R8: A recovery strobe sets the completion count to 0 and the submission count to the number of pending packets. `slot_o` then shows that number, and other strobes in the same cycle are ignored.
- R9: After reset, `slot_o` is 0 and `full_o` is 0.
- R10: A submission and a completion in the same cycle both take effect, leaving the pending count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_i | input | 1 | Host submits a packet this cycle |
| sub_len_i | input | 13 | Packet length in bytes |
| sub_addr_i | input | 32 | Packet buffer start address |
| thresh_i | input | 11 | Transmit FIFO threshold in bytes |
| done_i | input | 1 | Engine finished the oldest pending packet |
| recover_i | input | 1 | Restart ring after engine reset |
| slot_o | output | 2 | Slot for the next submission |
| word_o | output | 32 | Status/length word for that slot |
| full_o | output | 1 | All slots in flight |
| copy_o | output | 1 | Buffer misaligned, bounce copy needed |

## Verification
The assertions take the strobes to be single-cycle and the counts to move only through them. They assume the length input never exceeds the 13-bit field, so the padded length can be compared directly against the minimum. The directed stimulus drives each strobe for exactly one clock and changes inputs only on the falling edge. It deliberately strikes the ignored cases: a submit while full, a completion while empty, and a recovery with pending packets at a nonzero completion index. Format cases sit on both sides of the 60-byte boundary and cover every low-address pattern.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
   localparam int unsigned ETH_MIN_FRAME = 60;

   function automatic int unsigned log2_ceil(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/tx_ring_ctr.sv
module tx_ring_ctr #(
   parameter int unsigned NUM   = 4,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sub_i,
   input  logic             done_i,
   input  logic             rec_i,
   output logic [CNT_W-1:0] prod_o,
   output logic [CNT_W-1:0] cons_o,
   output logic             full_o
);
   localparam logic [CNT_W-1:0] NUM_C = CNT_W'(NUM);

   logic [CNT_W-1:0] prod_q, cons_q, pend;
   logic             full, empty;

   assign pend  = prod_q - cons_q;
   assign full  = (pend >= NUM_C);
   assign empty = (pend == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prod_q <= '0;
         cons_q <= '0;
      end else if (rec_i) begin
         cons_q <= '0;
         prod_q <= pend;
      end else begin
         if (sub_i && !full)   prod_q <= prod_q + 1'b1;
         if (done_i && !empty) cons_q <= cons_q + 1'b1;
      end
   end

   assign prod_o = prod_q;
   assign cons_o = cons_q;
   assign full_o = full;
endmodule

// File: rtl/tx_word_form.sv
module tx_word_form #(
   parameter int unsigned LEN_W     = 13,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned THR_W     = 11,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned THR_SHIFT = 11,
   parameter int unsigned FLD_LO    = 16,
   parameter int unsigned FLD_HI    = 21,
   parameter int unsigned ALIGN_LG  = 2,
   parameter int unsigned MIN_LEN   = 60
) (
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic [WORD_W-1:0] word_o,
   output logic              copy_o
);
   localparam logic [WORD_W-1:0] FLD_MASK =
      WORD_W'(((64'd1 << (FLD_HI - FLD_LO + 1)) - 64'd1) << FLD_LO);
   localparam logic [LEN_W-1:0] MIN_C = LEN_W'(MIN_LEN);

   initial begin
      if (FLD_LO < LEN_W)   $error("threshold field overlaps length field");
      if (FLD_HI >= WORD_W) $error("threshold field beyond word");
      if (MIN_LEN >= (1 << LEN_W)) $error("minimum frame does not fit");
   end

   logic [LEN_W-1:0]  len_pad;
   logic [WORD_W-1:0] thr_fld;

   always_comb begin
      len_pad = (len_i < MIN_C) ? MIN_C : len_i;
      thr_fld = (WORD_W'(thr_i) << THR_SHIFT) & FLD_MASK;
      word_o  = thr_fld | WORD_W'(len_pad);
   end

   generate
      if (ALIGN_LG == 0) begin : g_no_align
         assign copy_o = 1'b0;
      end else begin : g_align
         assign copy_o = |addr_i[ALIGN_LG-1:0];
      end
   endgenerate
endmodule

// File: rtl/tx_slot_ring.sv
module tx_slot_ring
   import tx_ring_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned LEN_W     = 13,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned THR_W     = 11,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned THR_SHIFT = 11,
   parameter int unsigned FLD_LO    = 16,
   parameter int unsigned FLD_HI    = 21,
   parameter int unsigned ALIGN_LG  = 2,
   parameter int unsigned IDX_W     = log2_ceil(NUM_SLOTS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sub_i,
   input  logic [LEN_W-1:0]  sub_len_i,
   input  logic [ADDR_W-1:0] sub_addr_i,
   input  logic [THR_W-1:0]  thresh_i,
   input  logic              done_i,
   input  logic              recover_i,
   output logic [IDX_W-1:0]  slot_o,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o,
   output logic              copy_o
);
   localparam int unsigned CNT_W = IDX_W + 1;

   initial begin
      if (NUM_SLOTS < 2 || (1 << IDX_W) != NUM_SLOTS)
         $error("slot count must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] prod_cnt, cons_cnt;

   tx_ring_ctr #(.NUM(NUM_SLOTS), .CNT_W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sub_i (sub_i),
      .done_i(done_i),
      .rec_i (recover_i),
      .prod_o(prod_cnt),
      .cons_o(cons_cnt),
      .full_o(full_o)
   );

   tx_word_form #(
      .LEN_W(LEN_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .WORD_W(WORD_W),
      .THR_SHIFT(THR_SHIFT), .FLD_LO(FLD_LO), .FLD_HI(FLD_HI),
      .ALIGN_LG(ALIGN_LG), .MIN_LEN(ETH_MIN_FRAME)
   ) u_form (
      .len_i (sub_len_i),
      .addr_i(sub_addr_i),
      .thr_i (thresh_i),
      .word_o(word_o),
      .copy_o(copy_o)
   );

   assign slot_o = prod_cnt[IDX_W-1:0];
endmodule

// File: rtl/tx_slot_ring_chk.sv
module tx_slot_ring_chk #(
   parameter int unsigned NUM     = 4,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned LEN_W   = 13,
   parameter int unsigned MIN_LEN = 60
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sub_i,
   input logic             done_i,
   input logic             rec_i,
   input logic             full_i,
   input logic [LEN_W-1:0] len_fld_i,
   input logic [CNT_W-1:0] prod_i,
   input logic [CNT_W-1:0] cons_i
);
   a_r5_pending_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CNT_W'(prod_i - cons_i) <= CNT_W'(NUM)));

   a_r1_submit_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_i && !full_i && !rec_i) |=> (prod_i == CNT_W'($past(prod_i) + 1'b1)));

   a_r6_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_i && full_i && !rec_i) |=> $stable(prod_i));

   a_r7_empty_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && (prod_i == cons_i) && !rec_i) |=> $stable(cons_i));

   a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_i |=> ((cons_i == '0) && (prod_i == CNT_W'($past(prod_i) - $past(cons_i)))));

   a_r3_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (len_fld_i >= LEN_W'(MIN_LEN)));
endmodule

bind tx_slot_ring tx_slot_ring_chk #(
   .NUM(NUM_SLOTS), .CNT_W(CNT_W), .LEN_W(LEN_W), .MIN_LEN(tx_ring_pkg::ETH_MIN_FRAME)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .sub_i    (sub_i),
   .done_i   (done_i),
   .rec_i    (recover_i),
   .full_i   (full_o),
   .len_fld_i(word_o[LEN_W-1:0]),
   .prod_i   (prod_cnt),
   .cons_i   (cons_cnt)
);

// File: tb/tx_slot_ring_bench.sv
module tx_slot_ring_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sub = 1'b0, done = 1'b0, rec = 1'b0;
   logic [12:0] len = 13'd100;
   logic [31:0] addr = 32'h0;
   logic [10:0] thr = 11'd0;
   logic [1:0]  slot;
   logic [31:0] word;
   logic        full, copy;
   int          n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   tx_slot_ring u_tx_slot_ring (
      .clk_i(clk), .rst_ni(rst_n), .sub_i(sub), .sub_len_i(len),
      .sub_addr_i(addr), .thresh_i(thr), .done_i(done), .recover_i(rec),
      .slot_o(slot), .word_o(word), .full_o(full), .copy_o(copy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic s, input logic d, input logic r);
      @(negedge clk);
      sub = s; done = d; rec = r;
      @(negedge clk);
      sub = 1'b0; done = 1'b0; rec = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9 slot", 32'(slot), 0);
      chk("R9 full", 32'(full), 0);
   endtask

   task automatic t_format();
      int lens[4] = '{20, 59, 60, 1514};
      int pads[4] = '{60, 60, 60, 1514};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); len = 13'(lens[i]); thr = 11'd0; #1;
         chk("R3 padded length", word, 32'(pads[i]));
      end
      @(negedge clk); len = 13'd100; thr = 11'h7FF; #1;
      chk("R4 full threshold", word, 32'h003F_0064);
      @(negedge clk); thr = 11'd160; #1;
      chk("R4 threshold 160", word, 32'h0005_0064);
      @(negedge clk); thr = 11'h01F; #1;
      chk("R4 low bits dropped", word, 32'h0000_0064);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk); addr = 32'h1000 + 32'(a); #1;
         chk("R2 copy flag", 32'(copy), (a != 0) ? 1 : 0);
      end
   endtask

   task automatic t_fill_and_block();
      do_reset();
      for (int i = 0; i < 4; i++) begin
         chk("R1 slot before submit", 32'(slot), 32'(i));
         chk("R5 not full yet", 32'(full), 0);
         strobe(1'b1, 1'b0, 1'b0);
      end
      chk("R1 slot wrapped", 32'(slot), 0);
      chk("R5 full at four", 32'(full), 1);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R6 submit ignored slot", 32'(slot), 0);
      chk("R6 submit ignored full", 32'(full), 1);
      strobe(1'b0, 1'b1, 1'b0);
      chk("R5 full clears on completion", 32'(full), 0);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R5 full again", 32'(full), 1);
      chk("R6 slot after refill", 32'(slot), 1);
   endtask

   task automatic t_empty_done();
      do_reset();
      strobe(1'b1, 1'b0, 1'b0);
      strobe(1'b0, 1'b1, 1'b0);
      strobe(1'b0, 1'b1, 1'b0);
      strobe(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) strobe(1'b1, 1'b0, 1'b0);
      chk("R7 extra completion ignored, three pending", 32'(full), 0);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R7 full after four", 32'(full), 1);
   endtask

   task automatic t_simul();
      do_reset();
      strobe(1'b1, 1'b0, 1'b0);
      strobe(1'b1, 1'b0, 1'b0);
      strobe(1'b1, 1'b1, 1'b0);
      chk("R10 slot advanced", 32'(slot), 3);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R10 three pending", 32'(full), 0);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R10 four pending", 32'(full), 1);
   endtask

   task automatic t_recover();
      do_reset();
      for (int i = 0; i < 3; i++) strobe(1'b1, 1'b0, 1'b0);
      strobe(1'b0, 1'b1, 1'b0);
      strobe(1'b1, 1'b1, 1'b1);
      chk("R8 slot equals pending", 32'(slot), 2);
      chk("R8 not full", 32'(full), 0);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R8 next slot", 32'(slot), 3);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R8 full after refill", 32'(full), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_format();
      t_fill_and_block();
      t_empty_done();
      t_simul();
      t_recover();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule